// File: doc/BRIEF.md
# CAN Controller Enable and Bus-Integration Front End

This block is the control front end of a CAN controller. It decides when the controller joins the network, holds the transmit and receive error counters and the sticky error flags, and supports a listen-only bit-rate search mode. It does not do bit timing, framing, stuffing, CRC, arbitration or mailboxes. Those parts reach it through a bit-time strobe, the sampled receive bit and error-event inputs.

Software writes the bit-rate configuration first, which raises `cfg_valid`. It then raises `enable_req`. The first cycle in which both are high starts the controller. A one-cycle pulse resets the protocol state machine, and the counters and flags are cleared. The block then waits for a run of recessive bits on the bus. When the run is complete, `bus_synced` goes high. While `autobaud` is set, errors are still recorded in the flags but the counters are frozen, so software can test a candidate bit rate without damaging the error state.

Top module: `can_busint_ctrl`

## Requirements
- R1: After reset, `active`, `bus_synced`, `sm_reset`, `cnt_lock`, `tec`, `rec` and `err_flags` are all 0.
- R2: While `cfg_valid` is 0, a disabled controller stays disabled whatever `enable_req` does. With both inputs at 1 on a disabled controller, `active` is 1 after the next clock edge.
- R3: In the cycle in which `active` first reads 1, `sm_reset` is 1 for exactly that cycle, and `tec`, `rec` and `err_flags` read 0.
- R4: While active and unsynchronized, each clock with `bit_strobe`=1 and `rx_bit`=1 (1 = recessive) counts one recessive bit. `bus_synced` rises after the edge that counts the 11th consecutive recessive bit, and not before.
- R5: A strobed dominant bit (`rx_bit`=0) during integration restarts the count from zero. Clocks without `bit_strobe` do not advance the count.
- R6: `cnt_lock` equals `active` AND `autobaud`. While it is 1, `tec` and `rec` do not change on error events.
- R7: While active, any bit set in `err_ev` is OR-ed into the sticky `err_flags`, in both normal and autobaud mode.
- R8: Clearing `autobaud` while active leaves `bus_synced` unchanged and restores normal counting.
- R9: Dropping `enable_req` while active clears `active` and `bus_synced` after the next edge. A later enable must integrate again from zero.
- R10: In normal mode, an error event (`err_ev` not 0) adds 8 to `tec` when `err_tx`=1 and adds 1 to `rec` when `err_tx`=0. Both counters saturate at 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_valid | input | 1 | Bit-rate configuration has been written |
| enable_req | input | 1 | Software enable flag (level) |
| autobaud | input | 1 | Listen-only bit-rate search mode |
| bit_strobe | input | 1 | One pulse per bit time |
| rx_bit | input | 1 | Sampled bus bit, 1 = recessive |
| err_ev | input | NERR | Error events by type, one bit per type |
| err_tx | input | 1 | The error events in this cycle happened while transmitting |
| active | output | 1 | Controller is enabled |
| bus_synced | output | 1 | Bus integration is complete |
| sm_reset | output | 1 | One-cycle reset pulse to the protocol state machine |
| cnt_lock | output | 1 | Error counters are frozen |
| tec | output | CW | Transmit error counter |
| rec | output | CW | Receive error counter |
| err_flags | output | NERR | Sticky error flags |

## Verification
The hardest state to reach from the ports is the counter ceiling. Reaching 255 on `rec` takes hundreds of error events with no disable in between, and random toggling of `enable_req` keeps resetting the counters. A directed phase therefore holds the controller enabled and drives long runs of transmit and receive errors past the ceiling. Integration needs eleven strobed recessive bits in a row. Random traffic is biased strongly toward recessive bits, and a directed run places a dominant bit at position ten to show that the count restarts.

// File: rtl/can_busint_ctrl.sv
module can_busint_ctrl #(
  parameter int CW        = 8,
  parameter int NERR      = 5,
  parameter int IDLE_BITS = 11,
  parameter int RX_INC    = 1,
  parameter int TX_INC    = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_valid,
  input  logic            enable_req,
  input  logic            autobaud,
  input  logic            bit_strobe,
  input  logic            rx_bit,
  input  logic [NERR-1:0] err_ev,
  input  logic            err_tx,
  output logic            active,
  output logic            bus_synced,
  output logic            sm_reset,
  output logic            cnt_lock,
  output logic [CW-1:0]   tec,
  output logic [CW-1:0]   rec,
  output logic [NERR-1:0] err_flags
);
  localparam int IW = $clog2(IDLE_BITS + 1);
  localparam logic [CW:0] CMAX = {1'b0, {CW{1'b1}}};

  logic [IW-1:0] run;

  function automatic logic [CW-1:0] sat_add(input logic [CW-1:0] a, input int inc);
    logic [CW:0] s;
    s = {1'b0, a} + (CW+1)'(inc);
    return (s > CMAX) ? CMAX[CW-1:0] : s[CW-1:0];
  endfunction

  assign cnt_lock = active & autobaud;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      bus_synced <= 1'b0;
      sm_reset   <= 1'b0;
      run        <= '0;
      tec        <= '0;
      rec        <= '0;
      err_flags  <= '0;
    end else begin
      sm_reset <= 1'b0;
      if (!active) begin
        bus_synced <= 1'b0;
        run        <= '0;
        if (enable_req && cfg_valid) begin
          active    <= 1'b1;
          sm_reset  <= 1'b1;
          tec       <= '0;
          rec       <= '0;
          err_flags <= '0;
        end
      end else if (!enable_req) begin
        active     <= 1'b0;
        bus_synced <= 1'b0;
        run        <= '0;
      end else begin
        if (!bus_synced && bit_strobe) begin
          if (!rx_bit)
            run <= '0;
          else if (run == IW'(IDLE_BITS - 1)) begin
            bus_synced <= 1'b1;
            run        <= '0;
          end else
            run <= run + 1'b1;
        end
        err_flags <= err_flags | err_ev;
        if (|err_ev && !autobaud) begin
          if (err_tx) tec <= sat_add(tec, TX_INC);
          else        rec <= sat_add(rec, RX_INC);
        end
      end
    end
  end
endmodule

module can_busint_ctrl_chk #(
  parameter int CW   = 8,
  parameter int NERR = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_valid,
  input logic            enable_req,
  input logic            autobaud,
  input logic            bit_strobe,
  input logic            rx_bit,
  input logic            active,
  input logic            bus_synced,
  input logic            sm_reset,
  input logic            cnt_lock,
  input logic [CW-1:0]   tec,
  input logic [CW-1:0]   rec,
  input logic [NERR-1:0] err_flags
);
  p_cfg_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !cfg_valid) |=> !active);

  p_enable_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> (sm_reset && tec == '0 && rec == '0 && err_flags == '0));

  p_pulse_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sm_reset |=> !sm_reset);

  p_sync_on_recessive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_synced) |-> $past(bit_strobe && rx_bit && active));

  p_lock_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && autobaud && enable_req) |=> ($stable(tec) && $stable(rec)));

  p_sticky_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && enable_req) |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

  p_disable_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !enable_req) |=> (!active && !bus_synced));

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (active && enable_req && tec == {CW{1'b1}}) |=> tec == {CW{1'b1}});
endmodule

bind can_busint_ctrl can_busint_ctrl_chk #(.CW(CW), .NERR(NERR)) u_chk (.*);

// File: tb/can_busint_ctrl_bench.sv
module can_busint_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NERR = 5;

  logic clk = 0, rst_n = 0;
  logic cfg_valid = 0, enable_req = 0, autobaud = 0, bit_strobe = 0, rx_bit = 1, err_tx = 0;
  logic [NERR-1:0] err_ev = '0;
  logic active, bus_synced, sm_reset, cnt_lock;
  logic [7:0] tec, rec;
  logic [NERR-1:0] err_flags;

  int checks = 0, fails = 0;
  bit m_en, m_sync, m_pulse;
  int m_run, m_tec, m_rec;
  logic [NERR-1:0] m_flags;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_busint_ctrl u_can_busint_ctrl (.*);

  initial begin
    #(CLK_PERIOD*200000);
    fails++;
    $display("FAIL watchdog expired: actual hung, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  function automatic int sat(input int a, input int inc);
    return (a + inc > 255) ? 255 : a + inc;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_step();
    m_pulse = 0;
    if (!m_en) begin
      m_sync = 0; m_run = 0;
      if (enable_req && cfg_valid) begin
        m_en = 1; m_pulse = 1; m_tec = 0; m_rec = 0; m_flags = '0;
      end
    end else if (!enable_req) begin
      m_en = 0; m_sync = 0; m_run = 0;
    end else begin
      if (!m_sync && bit_strobe) begin
        if (!rx_bit) m_run = 0;
        else if (m_run == 10) begin m_sync = 1; m_run = 0; end
        else m_run++;
      end
      m_flags |= err_ev;
      if (err_ev != 0 && !autobaud) begin
        if (err_tx) m_tec = sat(m_tec, 8);
        else m_rec = sat(m_rec, 1);
      end
    end
  endtask

  task automatic cyc();
    model_step();
    @(posedge clk); #1;
    chk("R2 active", active, m_en);
    chk("R3 sm_reset", sm_reset, m_pulse);
    chk("R4 bus_synced", bus_synced, m_sync);
    chk("R6 cnt_lock", cnt_lock, m_en && autobaud);
    chk("R10 tec", tec, m_tec);
    chk("R10 rec", rec, m_rec);
    chk("R7 err_flags", err_flags, m_flags);
    @(negedge clk);
  endtask

  task automatic drive(input bit cv, input bit en, input bit ab, input bit st,
                       input bit rx, input logic [NERR-1:0] ev, input bit tx);
    cfg_valid = cv; enable_req = en; autobaud = ab; bit_strobe = st;
    rx_bit = rx; err_ev = ev; err_tx = tx;
    cyc();
  endtask

  initial begin
    void'($urandom(32'd1234));
    m_en = 0; m_sync = 0; m_pulse = 0; m_run = 0; m_tec = 0; m_rec = 0; m_flags = '0;
    @(negedge clk);
    chk("R1 active", active, 0); chk("R1 bus_synced", bus_synced, 0);
    chk("R1 sm_reset", sm_reset, 0); chk("R1 tec", tec, 0);
    chk("R1 rec", rec, 0); chk("R1 err_flags", err_flags, 0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < 5; i++) drive(0, 1, 0, 1, 1, '0, 0);
    chk("R2 no enable without config", active, 0);
    drive(1, 1, 0, 1, 1, '0, 0);
    chk("R3 reset pulse at enable", sm_reset, 1);

    for (int i = 0; i < 9; i++) drive(1, 1, 0, 1, 1, '0, 0);
    drive(1, 1, 0, 1, 0, '0, 0);
    chk("R5 dominant restarts", bus_synced, 0);
    for (int i = 0; i < 10; i++) begin
      drive(1, 1, 0, 0, 1, '0, 0);
      drive(1, 1, 0, 1, 1, '0, 0);
    end
    chk("R5 ten recessive not enough", bus_synced, 0);
    drive(1, 1, 0, 1, 1, '0, 0);
    chk("R4 synced on eleventh", bus_synced, 1);

    drive(1, 1, 1, 1, 1, 5'b00101, 1);
    chk("R6 tec frozen", tec, 0);
    chk("R7 flags in autobaud", err_flags, 5'b00101);
    drive(1, 1, 0, 1, 1, '0, 0);
    chk("R8 sync kept after autobaud off", bus_synced, 1);
    drive(1, 1, 0, 1, 1, 5'b00010, 1);
    chk("R8 counting restored", tec, 8);

    for (int i = 0; i < 40; i++) drive(1, 1, 0, 0, 1, 5'b00001, 1);
    chk("R10 tec saturates", tec, 255);
    for (int i = 0; i < 300; i++) drive(1, 1, 0, 0, 1, 5'b10000, 0);
    chk("R10 rec saturates", rec, 255);

    drive(1, 0, 0, 1, 1, '0, 0);
    chk("R9 disable clears active", active, 0);
    chk("R9 disable clears sync", bus_synced, 0);
    drive(1, 1, 0, 1, 1, '0, 0);
    chk("R3 counters cleared", tec + rec, 0);
    drive(1, 1, 0, 1, 1, '0, 0);
    chk("R9 integrates again", bus_synced, 0);

    for (int i = 0; i < 4000; i++) begin
      drive(($urandom % 20) != 0, ($urandom % 60) != 0, ($urandom % 8) == 0,
            ($urandom % 3) != 0, ($urandom % 25) != 0,
            (($urandom % 4) == 0) ? NERR'($urandom) : '0, $urandom % 2);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule